// File: doc/BRIEF.md
# Page Operation Sequencer

This block runs the self-timed internal page operations of a serial flash once the front end has decoded a command. On a launch pulse it takes an operation code, a buffer select and a page address. It then moves whole pages, one word per cycle, between one of two page buffers and the main array. All storage lives outside the block, reached through two single-word ports: one on the buffer side and one on the array side. Both ports read combinationally and write on the clock edge.

Three operations are supported. Program erases the addressed page to all ones and then copies the selected buffer into it. Transfer copies the page into the selected buffer. Rewrite performs a transfer and then a program of that same buffer back into the same page. Each phase is held open until a cycle-count timer standing in for the device timing has run out. A phase therefore lasts the longer of its copy length and its timer. Ready/busy is shown both on an active-low-busy pin and in bit 7 of an eight-bit status byte.

Top module: `page_op_seq`

## Requirements
- R1: After reset, `ready_o` is 1, `status_o` is 8'h80, and neither write enable is active.
- R2: A launch with a non-zero code while idle makes the block busy from the next cycle: `ready_o` is 0 and `status_o[7]` is 0 for every busy cycle, and the two always agree.
- R3: Program (code 2'b01) first writes all ones to page words 0 to PAGE_WORDS-1 in ascending order. Only after that does it write buffer words 0 to PAGE_WORDS-1, in ascending order, to the same word addresses.
- R4: Program stays busy for exactly max(2*PAGE_WORDS, T_EP) cycles.
- R5: Transfer (code 2'b10) copies every word of the page into the selected buffer and stays busy for max(PAGE_WORDS, T_XFR) cycles. The array is not written.
- R6: Rewrite (code 2'b11) transfers the page into the selected buffer and then programs that buffer back into the same page. It stays busy for the sum of the transfer span and the program span.
- R7: `buf_sel` 0 selects buffer index 0 and `buf_sel` 1 selects buffer index 1. The other buffer is never written.
- R8: A launch that arrives while busy is ignored, including one in the final busy cycle. The block returns to ready in the normal cycle and stays ready.
- R9: A launch with code 2'b00 is ignored: the block stays ready.
- R10: No buffer or array write happens while `ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| launch | input | 1 | One-cycle start pulse from the front end |
| op | input | 2 | Operation code: 01 program, 10 transfer, 11 rewrite, 00 none |
| buf_sel | input | 1 | Buffer to use (0 or 1) |
| page_addr | input | PAGE_AW | Main-array page |
| ready_o | output | 1 | Ready/busy pin, low while busy |
| status_o | output | 8 | Status byte, bit 7 set when ready, other bits 0 |
| buf_idx_o | output | 1 | Buffer selected on the buffer port |
| buf_addr_o | output | log2(PAGE_WORDS) | Buffer word address |
| buf_wdata_o | output | WORD_W | Buffer write data |
| buf_we_o | output | 1 | Buffer write enable |
| buf_rdata_i | input | WORD_W | Buffer read data (combinational) |
| arr_page_o | output | PAGE_AW | Array page address |
| arr_addr_o | output | log2(PAGE_WORDS) | Array word address |
| arr_wdata_o | output | WORD_W | Array write data |
| arr_we_o | output | 1 | Array write enable |
| arr_rdata_i | input | WORD_W | Array read data (combinational) |

## Verification
A new launch can coincide with the completion of the previous operation. The final busy cycle is the same cycle in which the sequencer would otherwise accept a start. The bench provokes this by raising launch exactly at the last busy cycle of a program, counted from the busy span it expects. It judges the result by requiring the block to be ready on the next cycle and to stay ready with no writes. A second launch one cycle later must then be accepted at once.

// File: rtl/page_seq_pkg.sv
package page_seq_pkg;
    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_PROG = 2'b01,
        OP_XFER = 2'b10,
        OP_REWR = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'b00,
        PH_XFER = 2'b01,
        PH_PROG = 2'b10
    } phase_e;
endpackage

// File: rtl/page_seq_span.sv
module page_seq_span #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          advance,
    input  logic [CW-1:0] limit,
    output logic [CW-1:0] cnt_q,
    output logic          last
);
    logic [CW-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (restart)      cnt_d = '0;
        else if (advance) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last = (cnt_q == limit - 1'b1);

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        advance |-> (cnt_q < limit));
endmodule

// File: rtl/page_seq_move.sv
module page_seq_move
    import page_seq_pkg::*;
#(
    parameter int PAGE_WORDS = 8,
    parameter int WORD_W     = 8,
    parameter int CW         = 6,
    localparam int WAW       = $clog2(PAGE_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_e            phase,
    input  logic [CW-1:0]     cnt,
    input  logic [WORD_W-1:0] buf_rdata,
    input  logic [WORD_W-1:0] arr_rdata,
    output logic [WAW-1:0]    buf_addr,
    output logic [WORD_W-1:0] buf_wdata,
    output logic              buf_we,
    output logic [WAW-1:0]    arr_addr,
    output logic [WORD_W-1:0] arr_wdata,
    output logic              arr_we
);
    localparam logic [CW-1:0] PW  = CW'(PAGE_WORDS);
    localparam logic [CW-1:0] PW2 = CW'(2 * PAGE_WORDS);

    logic [CW-1:0] off;
    assign off = cnt - PW;

    always_comb begin
        buf_addr  = '0;
        buf_wdata = arr_rdata;
        buf_we    = 1'b0;
        arr_addr  = '0;
        arr_wdata = '1;
        arr_we    = 1'b0;
        unique case (phase)
            PH_XFER: begin
                if (cnt < PW) begin
                    arr_addr = WAW'(cnt);
                    buf_addr = WAW'(cnt);
                    buf_we   = 1'b1;
                end
            end
            PH_PROG: begin
                if (cnt < PW) begin
                    arr_addr  = WAW'(cnt);
                    arr_wdata = {WORD_W{1'b1}};
                    arr_we    = 1'b1;
                end else if (cnt < PW2) begin
                    arr_addr  = WAW'(off);
                    buf_addr  = WAW'(off);
                    arr_wdata = buf_rdata;
                    arr_we    = 1'b1;
                end
            end
            default: ;
        endcase
    end

    // R5: a transfer never touches the array, a program never touches a buffer
    single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(buf_we && arr_we));
endmodule

// File: rtl/page_op_seq.sv
module page_op_seq
    import page_seq_pkg::*;
#(
    parameter int PAGE_WORDS = 8,
    parameter int WORD_W     = 8,
    parameter int PAGE_AW    = 3,
    parameter int T_EP       = 24,
    parameter int T_XFR      = 5,
    localparam int WAW       = $clog2(PAGE_WORDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               launch,
    input  logic [1:0]         op,
    input  logic               buf_sel,
    input  logic [PAGE_AW-1:0] page_addr,
    output logic               ready_o,
    output logic [7:0]         status_o,
    output logic               buf_idx_o,
    output logic [WAW-1:0]     buf_addr_o,
    output logic [WORD_W-1:0]  buf_wdata_o,
    output logic               buf_we_o,
    input  logic [WORD_W-1:0]  buf_rdata_i,
    output logic [PAGE_AW-1:0] arr_page_o,
    output logic [WAW-1:0]     arr_addr_o,
    output logic [WORD_W-1:0]  arr_wdata_o,
    output logic               arr_we_o,
    input  logic [WORD_W-1:0]  arr_rdata_i
);
    localparam int SPAN_PROG = (2 * PAGE_WORDS > T_EP) ? 2 * PAGE_WORDS : T_EP;
    localparam int SPAN_XFER = (PAGE_WORDS > T_XFR) ? PAGE_WORDS : T_XFR;
    localparam int SPAN_MAX  = (SPAN_PROG > SPAN_XFER) ? SPAN_PROG : SPAN_XFER;
    localparam int CW        = $clog2(SPAN_MAX + 1);

    typedef struct packed {
        phase_e             phase;
        logic               chain;
        logic               sel;
        logic [PAGE_AW-1:0] page;
    } seq_t;

    seq_t          seq_d, seq_q;
    logic          restart, advance, last;
    logic [CW-1:0] cnt_q, limit;

    assign limit = (seq_q.phase == PH_PROG) ? CW'(SPAN_PROG) : CW'(SPAN_XFER);

    always_comb begin
        seq_d   = seq_q;
        restart = 1'b1;
        advance = 1'b0;
        unique case (seq_q.phase)
            PH_IDLE: begin
                if (launch && op != OP_NONE) begin
                    seq_d.sel   = buf_sel;
                    seq_d.page  = page_addr;
                    seq_d.chain = (op == OP_REWR);
                    seq_d.phase = (op == OP_PROG) ? PH_PROG : PH_XFER;
                end
            end
            PH_XFER, PH_PROG: begin
                if (last) begin
                    seq_d.phase = (seq_q.phase == PH_XFER && seq_q.chain) ? PH_PROG : PH_IDLE;
                    seq_d.chain = 1'b0;
                end else begin
                    restart = 1'b0;
                    advance = 1'b1;
                end
            end
            default: seq_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{phase: PH_IDLE, chain: 1'b0, sel: 1'b0, page: '0};
        else        seq_q <= seq_d;
    end

    page_seq_span #(.CW(CW)) u_span (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .advance (advance),
        .limit   (limit),
        .cnt_q   (cnt_q),
        .last    (last)
    );

    page_seq_move #(.PAGE_WORDS(PAGE_WORDS), .WORD_W(WORD_W), .CW(CW)) u_move (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (seq_q.phase),
        .cnt       (cnt_q),
        .buf_rdata (buf_rdata_i),
        .arr_rdata (arr_rdata_i),
        .buf_addr  (buf_addr_o),
        .buf_wdata (buf_wdata_o),
        .buf_we    (buf_we_o),
        .arr_addr  (arr_addr_o),
        .arr_wdata (arr_wdata_o),
        .arr_we    (arr_we_o)
    );

    assign ready_o    = (seq_q.phase == PH_IDLE);
    assign status_o   = {ready_o, 7'b0};
    assign buf_idx_o  = seq_q.sel;
    assign arr_page_o = seq_q.page;

    // R2
    busy_after_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && launch && op != OP_NONE) |=> !ready_o);
    // R9
    null_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && launch && op == OP_NONE) |=> ready_o);
    // R10
    no_idle_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_we_o || arr_we_o) |-> !ready_o);
    // R4
    span_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready_o && last && seq_q.phase == PH_PROG) |=> ready_o);
endmodule

// File: tb/page_op_seq_test.sv
module page_op_seq_test;
    localparam int PW = 8, WW = 8, PAW = 3, TEP = 24, TXF = 5;
    localparam int SPROG = (2 * PW > TEP) ? 2 * PW : TEP;
    localparam int SXFER = (PW > TXF) ? PW : TXF;

    typedef struct packed {
        logic [1:0] op;
        logic       sel;
        logic [2:0] page;
        logic [7:0] busy;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{2'b01, 1'b0, 3'd3, 8'(SPROG)},
        '{2'b10, 1'b1, 3'd3, 8'(SXFER)},
        '{2'b11, 1'b0, 3'd5, 8'(SXFER + SPROG)},
        '{2'b01, 1'b1, 3'd7, 8'(SPROG)},
        '{2'b10, 1'b0, 3'd0, 8'(SXFER)},
        '{2'b00, 1'b1, 3'd2, 8'd0}
    };

    logic clk = 1'b0, rst_n = 1'b0, launch = 1'b0, buf_sel = 1'b0;
    logic [1:0] op = 2'b00;
    logic [PAW-1:0] page_addr = '0;
    logic ready_o, buf_idx_o, buf_we_o, arr_we_o;
    logic [7:0] status_o;
    logic [2:0] buf_addr_o, arr_addr_o;
    logic [PAW-1:0] arr_page_o;
    logic [WW-1:0] buf_wdata_o, arr_wdata_o, buf_rdata_i, arr_rdata_i;

    logic [WW-1:0] bmem [2][PW];
    logic [WW-1:0] amem [8][PW];
    logic [WW-1:0] ebuf [2][PW];
    logic [WW-1:0] earr [8][PW];

    int checks = 0, fails = 0;
    int arr_wcnt = 0, order_err = 0, idle_wr = 0, st_err = 0;
    logic [PAW-1:0] cur_page = '0;

    always #2 clk = ~clk;

    page_op_seq uut (
        .clk(clk), .rst_n(rst_n), .launch(launch), .op(op), .buf_sel(buf_sel),
        .page_addr(page_addr), .ready_o(ready_o), .status_o(status_o),
        .buf_idx_o(buf_idx_o), .buf_addr_o(buf_addr_o), .buf_wdata_o(buf_wdata_o),
        .buf_we_o(buf_we_o), .buf_rdata_i(buf_rdata_i), .arr_page_o(arr_page_o),
        .arr_addr_o(arr_addr_o), .arr_wdata_o(arr_wdata_o), .arr_we_o(arr_we_o),
        .arr_rdata_i(arr_rdata_i)
    );

    assign buf_rdata_i = bmem[buf_idx_o][buf_addr_o];
    assign arr_rdata_i = amem[arr_page_o][arr_addr_o];

    always @(posedge clk) begin
        if (rst_n) begin
            if ((buf_we_o || arr_we_o) && ready_o) idle_wr <= idle_wr + 1;
            if (buf_we_o) bmem[buf_idx_o][buf_addr_o] <= buf_wdata_o;
            if (arr_we_o) begin
                amem[arr_page_o][arr_addr_o] <= arr_wdata_o;
                if (arr_page_o != cur_page) order_err <= order_err + 1;
                else if (arr_wcnt < PW) begin
                    if (arr_wdata_o != '1 || int'(arr_addr_o) != arr_wcnt) order_err <= order_err + 1;
                end else if (int'(arr_addr_o) != arr_wcnt - PW) order_err <= order_err + 1;
                arr_wcnt <= arr_wcnt + 1;
            end
        end
    end

    always @(negedge clk) if (rst_n && (status_o[7] != ready_o)) st_err <= st_err + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    task automatic fill(input int seed);
        for (int b = 0; b < 2; b++)
            for (int w = 0; w < PW; w++) bmem[b][w] = 8'(b * 64 + w * 5 + seed * 3 + 1);
        for (int p = 0; p < 8; p++)
            for (int w = 0; w < PW; w++) amem[p][w] = 8'((p * 16 + w) ^ (seed * 7));
        ebuf = bmem;
        earr = amem;
    endtask

    task automatic model(input logic [1:0] o, input logic s, input logic [2:0] p);
        if (o == 2'b10 || o == 2'b11)
            for (int w = 0; w < PW; w++) ebuf[s][w] = earr[p][w];
        if (o == 2'b01 || o == 2'b11)
            for (int w = 0; w < PW; w++) earr[p][w] = ebuf[s][w];
    endtask

    function automatic int mem_diff();
        int d = 0;
        for (int b = 0; b < 2; b++)
            for (int w = 0; w < PW; w++) if (bmem[b][w] != ebuf[b][w]) d++;
        for (int p = 0; p < 8; p++)
            for (int w = 0; w < PW; w++) if (amem[p][w] != earr[p][w]) d++;
        return d;
    endfunction

    task automatic run_op(input logic [1:0] o, input logic s, input logic [2:0] p, output int busy);
        @(negedge clk);
        op = o; buf_sel = s; page_addr = p; launch = 1'b1;
        cur_page = p; arr_wcnt = 0;
        @(negedge clk);
        launch = 1'b0; op = 2'b00; busy = 0;
        while (!ready_o && busy < 1000) begin
            busy++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        int busy, oe0;
        fill(0);
        repeat (2) @(negedge clk);
        // R1: reset state
        chk(ready_o == 1'b1, "R1 ready", ready_o, 1);
        chk(status_o == 8'h80, "R1 status", status_o, 8'h80);
        chk(!buf_we_o && !arr_we_o, "R1 writes", buf_we_o + arr_we_o, 0);
        rst_n = 1'b1;
        @(negedge clk);

        foreach (VEC[i]) begin
            fill(i + 1);
            model(VEC[i].op, VEC[i].sel, VEC[i].page);
            oe0 = order_err;
            run_op(VEC[i].op, VEC[i].sel, VEC[i].page, busy);
            @(negedge clk);
            // R4 R5 R6 R9: busy span
            chk(busy == int'(VEC[i].busy), $sformatf("R4/R5/R6/R9 span vec%0d", i), busy, VEC[i].busy);
            // R3 R5 R6 R7: memory contents, other buffer untouched
            chk(mem_diff() == 0, $sformatf("R3/R7 memory vec%0d", i), mem_diff(), 0);
            // R3: erase-then-copy order
            chk(order_err == oe0, $sformatf("R3 order vec%0d", i), order_err - oe0, 0);
        end

        // R8: launch in the final busy cycle is ignored
        fill(9);
        model(2'b01, 1'b0, 3'd1);
        @(negedge clk);
        op = 2'b01; buf_sel = 1'b0; page_addr = 3'd1; launch = 1'b1;
        cur_page = 3'd1; arr_wcnt = 0;
        @(negedge clk);
        launch = 1'b0;
        // R2: busy in the cycle after launch
        chk(ready_o == 1'b0 && status_o[7] == 1'b0, "R2 busy next", ready_o, 0);
        for (int k = 1; k < SPROG; k++) @(negedge clk);
        chk(ready_o == 1'b0, "R8 still busy last cycle", ready_o, 0);
        op = 2'b10; buf_sel = 1'b1; page_addr = 3'd6; launch = 1'b1;
        @(negedge clk);
        launch = 1'b0; op = 2'b00;
        chk(ready_o == 1'b1, "R8 ready after end", ready_o, 1);
        repeat (3) @(negedge clk);
        chk(ready_o == 1'b1, "R8 stays ready", ready_o, 1);
        chk(mem_diff() == 0, "R8 memory", mem_diff(), 0);
        // R2: launch right after completion is accepted
        run_op(2'b10, 1'b1, 3'd6, busy);
        chk(busy == SXFER, "R2 accepted after end", busy, SXFER);

        // R10 and R2 monitors
        chk(idle_wr == 0, "R10 idle writes", idle_wr, 0);
        chk(st_err == 0, "R2 status/pin agree", st_err, 0);
        summary();
    end
endmodule